// File: doc/BRIEF.md
# Block Address Translation Decoder

This block keeps a small table of block-mapping entries. Each entry is a pair of 32-bit registers, an upper word and a lower word, and software loads them through a simple write port. The upper word holds three things: the effective base of the block, a length mask, and two privilege enables. The lower word holds the physical frame the block maps to.

On a lookup the block takes an effective address and a privilege mode. It reports whether a block mapping covers the address, which entry supplied it, and the physical address it forms. The result is registered and appears one cycle after the request. The block also gives continuous decoded status for every entry: the block length in KB, and a flag that marks a malformed length mask.

The block length is encoded as a run of ones in the mask, starting at the least significant bit. The smallest block is 128 KB, and each further set bit doubles the size. A mask with a gap in it is reported as a configuration error, and that entry can never hit.

Top module: `blk_xlate_dec`

## Requirements
- R1: After reset every entry reads as zero. The block then reports no hit, every length output is 0 and every error flag is 0.
- R2: A write with `wrLow`=0 loads the upper word of entry `wrIdx`, and a write with `wrLow`=1 loads its lower word. The new value governs the length, error and lookup logic from the next cycle on.
- R3: The length output of an entry is found from the mask field, upper word bits [12:2]. It is 0 when upper bits [1:0] are both clear. Otherwise it is 128 shifted left by the number of consecutive ones counted upward from mask bit 0.
- R4: The error flag of an entry is 1 when its mask holds a zero below some set bit. The flag depends only on the mask, whatever the enable bits are.
- R5: A supervisor lookup (`lkSuper`=1) can only hit entries whose upper bit 1 is set. A user lookup (`lkSuper`=0) can only hit entries whose upper bit 0 is set.
- R6: An enabled entry hits when lookup address bits [31:17] equal upper word bits [31:17] in every position not covered by the mask. Mask bit k covers address bit 17+k.
- R7: An entry whose error flag is set never produces a hit.
- R8: On a hit the physical address is built as follows. Bits [16:0] and every mask-covered bit come from the lookup address. The remaining upper bits come from the lower word of the winning entry.
- R9: When more than one entry hits, the entry with the lowest index is reported.
- R10: `hitValid` is high in exactly the cycle after a lookup request. A miss, or a cycle without a request, shows `hit`=0, `hitIdx`=0 and `physAddr`=0.
- R11: A lookup in the same cycle as a register write is decided with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write request |
| wrLow | input | 1 | 0 selects the upper word, 1 the lower word |
| wrIdx | input | 2 | Entry index for the write |
| wrData | input | 32 | Write data |
| lkValid | input | 1 | Lookup request |
| lkSuper | input | 1 | 1 for supervisor mode, 0 for user mode |
| lkAddr | input | 32 | Effective address to translate |
| hitValid | output | 1 | Lookup result is present |
| hit | output | 1 | A block entry covered the address |
| hitIdx | output | 2 | Index of the winning entry |
| physAddr | output | 32 | Translated physical address |
| cfgErr | output | 4 | Malformed-mask flag per entry |
| lenKb | output | 76 | Per-entry block length in KB, 19 bits each, entry i at [19i+18:19i] |

## Verification
A register write and a lookup can arrive in the same cycle. The bench provokes this by disabling the entry that covers an address while it looks that same address up. It expects the registered result to still report a hit from the old entry. A second lookup in the following cycle is then expected to miss. The priority path is also exercised by changing one of two overlapping entries between lookups, so that the reported winner moves from the lower index to the higher one.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  parameter int BAT_N    = 4;   // entries per table
  parameter int ADDR_W   = 32;  // address width
  parameter int OFF_W    = 17;  // log2 of the smallest block in bytes
  parameter int MASK_W   = 11;  // length mask width
  parameter int MASK_LSB = 2;   // mask position inside the upper word

  localparam int IDX_W   = $clog2(BAT_N);
  localparam int CMP_W   = ADDR_W - OFF_W;
  localparam int BASE_SH = OFF_W - 10;
  localparam int BASE_KB = 1 << BASE_SH;
  localparam int LEN_W   = BASE_SH + MASK_W + 1;
  localparam int ONES_W  = $clog2(MASK_W + 1);

  typedef struct packed {
    logic             wrGo;
    logic             wrLow;
    logic [IDX_W-1:0] wrIdx;
    logic             lkGo;
    logic             lkSuper;
  } strobe_t;
endpackage

// File: rtl/blk_xlate_ctrl.sv
module blk_xlate_ctrl
  import blk_xlate_pkg::*;
(
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrLow,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             lkValid,
  input  logic             lkSuper,
  output strobe_t          strobe
);
  // Requests are suppressed while reset is held
  always_comb begin
    strobe.wrGo    = wrEn & rstN;
    strobe.wrLow   = wrLow;
    strobe.wrIdx   = wrIdx;
    strobe.lkGo    = lkValid & rstN;
    strobe.lkSuper = lkSuper;
  end
endmodule

// File: rtl/blk_xlate_dp.sv
module blk_xlate_dp
  import blk_xlate_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       wrData,
  input  logic [ADDR_W-1:0]       lkAddr,
  output logic                    hitValid,
  output logic                    hit,
  output logic [IDX_W-1:0]        hitIdx,
  output logic [ADDR_W-1:0]       physAddr,
  output logic [BAT_N-1:0]        cfgErr,
  output logic [BAT_N*LEN_W-1:0]  lenKb
);
  logic [ADDR_W-1:0] upReg [BAT_N];
  logic [ADDR_W-1:0] loReg [BAT_N];
  logic [BAT_N-1:0]  entHit;
  logic [ADDR_W-1:0] entPa [BAT_N];

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BAT_N; i++) begin
        upReg[i] <= '0;
        loReg[i] <= '0;
      end
    end else if (strobe.wrGo) begin
      for (int i = 0; i < BAT_N; i++) begin
        if (strobe.wrIdx == IDX_W'(i)) begin
          if (strobe.wrLow) loReg[i] <= wrData;
          else              upReg[i] <= wrData;
        end
      end
    end
  end

  // Per-entry decode and match
  for (genvar g = 0; g < BAT_N; g++) begin : g_ent
    logic [MASK_W-1:0] mask;
    logic              maskBad;
    logic              anyEn;
    logic              modeEn;
    logic [ONES_W-1:0] runLen;
    logic [CMP_W-1:0]  care;

    assign mask    = upReg[g][MASK_LSB +: MASK_W];
    assign maskBad = |(mask & (mask + MASK_W'(1)));
    assign anyEn   = |upReg[g][1:0];
    assign modeEn  = strobe.lkSuper ? upReg[g][1] : upReg[g][0];
    assign care    = ~CMP_W'(mask);

    always_comb begin
      logic stop;
      stop   = 1'b0;
      runLen = '0;
      for (int b = 0; b < MASK_W; b++) begin
        if (!stop && mask[b]) runLen = runLen + ONES_W'(1);
        else                  stop   = 1'b1;
      end
    end

    assign cfgErr[g] = maskBad;
    assign lenKb[g*LEN_W +: LEN_W] = anyEn ? (LEN_W'(BASE_KB) << runLen) : '0;

    assign entHit[g] = modeEn && !maskBad &&
      (((lkAddr[ADDR_W-1:OFF_W] ^ upReg[g][ADDR_W-1:OFF_W]) & care) == '0);
    assign entPa[g]  = {(loReg[g][ADDR_W-1:OFF_W] & care) |
                        (lkAddr[ADDR_W-1:OFF_W] & ~care),
                        lkAddr[OFF_W-1:0]};

    // R2: an upper write lands on the next edge
    p_up_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrGo && !strobe.wrLow && strobe.wrIdx == IDX_W'(g))
        |=> (upReg[g] == $past(wrData)));
    // R3: disabled entries report zero length
    p_len_off_r3: assert property (@(posedge clk) disable iff (!rstN)
      (upReg[g][1:0] == 2'b00) |-> (lenKb[g*LEN_W +: LEN_W] == '0));
  end

  // Lowest index wins
  logic             anyHit;
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = BAT_N - 1; i >= 0; i--) begin
      if (entHit[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  // Registered result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hit      <= 1'b0;
      hitIdx   <= '0;
      physAddr <= '0;
    end else begin
      hitValid <= strobe.lkGo;
      hit      <= strobe.lkGo && anyHit;
      hitIdx   <= (strobe.lkGo && anyHit) ? selIdx : '0;
      physAddr <= (strobe.lkGo && anyHit) ? entPa[selIdx] : '0;
    end
  end

  // R10: result timing and quiet outputs
  p_lat_on_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lkGo |=> hitValid);
  p_lat_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lkGo |=> !hitValid);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (physAddr == '0 && hitIdx == '0));
  p_hit_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> hitValid);
endmodule

// File: rtl/blk_xlate_dec.sv
module blk_xlate_dec
  import blk_xlate_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   wrLow,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [ADDR_W-1:0]      wrData,
  input  logic                   lkValid,
  input  logic                   lkSuper,
  input  logic [ADDR_W-1:0]      lkAddr,
  output logic                   hitValid,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx,
  output logic [ADDR_W-1:0]      physAddr,
  output logic [BAT_N-1:0]       cfgErr,
  output logic [BAT_N*LEN_W-1:0] lenKb
);
  strobe_t strobe;

  blk_xlate_ctrl i_ctrl (
    .rstN(rstN), .wrEn(wrEn), .wrLow(wrLow), .wrIdx(wrIdx),
    .lkValid(lkValid), .lkSuper(lkSuper), .strobe(strobe)
  );

  blk_xlate_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .lkAddr(lkAddr), .hitValid(hitValid), .hit(hit), .hitIdx(hitIdx),
    .physAddr(physAddr), .cfgErr(cfgErr), .lenKb(lenKb)
  );
endmodule

// File: tb/test_blk_xlate_dec.sv
module test_blk_xlate_dec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrLow = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        lkValid = 1'b0, lkSuper = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        hitValid, hit;
  logic [1:0]  hitIdx;
  logic [31:0] physAddr;
  logic [3:0]  cfgErr;
  logic [75:0] lenKb;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  blk_xlate_dec i_blk_xlate_dec (.*);

  function automatic logic [31:0] mkUp(input logic [15:0] page, input logic [10:0] mask,
                                       input logic sv, input logic us);
    return {page, 3'b000, mask, sv, us};
  endfunction

  function automatic logic [18:0] lenOf(input int e);
    return lenKb[e*19 +: 19];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic low, input logic [31:0] d);
    wrEn = 1; wrLow = low; wrIdx = 2'(idx); wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
  endtask

  task automatic look(input logic sv, input logic [31:0] a);
    lkValid = 1; lkSuper = sv; lkAddr = a;
    @(posedge clk); @(negedge clk);
    lkValid = 0;
  endtask

  task automatic expHit(input string req, input int idx, input logic [31:0] pa);
    chk({req, " valid"}, 32'(hitValid), 1);
    chk({req, " hit"}, 32'(hit), 1);
    chk({req, " idx"}, 32'(hitIdx), 32'(idx));
    chk({req, " pa"}, physAddr, pa);
  endtask

  task automatic expMiss(input string req);
    chk({req, " valid"}, 32'(hitValid), 1);
    chk({req, " hit"}, 32'(hit), 0);
    chk({req, " idx"}, 32'(hitIdx), 0);
    chk({req, " pa"}, physAddr, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(hitValid), 0);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 err", 32'(cfgErr), 0);
    chk("R1 len", 32'(|lenKb), 0);
  endtask

  task automatic t_write_len;
    wr(0, 0, mkUp(16'h1000, 11'h000, 1, 0));
    wr(0, 1, 32'h8000_0000);
    chk("R2 R3 len e0", 32'(lenOf(0)), 128);
    wr(1, 0, mkUp(16'h2000, 11'h003, 1, 1));
    wr(1, 1, 32'h4006_0000);
    chk("R3 len e1", 32'(lenOf(1)), 512);
    wr(3, 0, mkUp(16'h5000, 11'h007, 0, 0));
    chk("R3 disabled len", 32'(lenOf(3)), 0);
    chk("R4 no err contiguous", 32'(cfgErr[3]), 0);
  endtask

  task automatic t_mask_err;
    wr(2, 0, mkUp(16'h3000, 11'h005, 1, 0));
    chk("R4 err e2", 32'(cfgErr[2]), 1);
    chk("R3 len partial run", 32'(lenOf(2)), 256);
    look(1, 32'h3000_0100);
    expMiss("R7 malformed");
    wr(3, 0, mkUp(16'h5000, 11'h002, 0, 0));
    chk("R4 err disabled", 32'(cfgErr[3]), 1);
    chk("R3 len disabled", 32'(lenOf(3)), 0);
    wr(2, 0, mkUp(16'h3000, 11'h7FF, 1, 0));
    chk("R3 max len", 32'(lenOf(2)), 262144);
    chk("R4 err cleared", 32'(cfgErr[2]), 0);
  endtask

  task automatic t_priv_match;
    look(1, 32'h1001_2345);
    expHit("R5 R8 sup", 0, 32'h8001_2345);
    look(0, 32'h1001_2345);
    expMiss("R5 user blocked");
    look(0, 32'h2007_0010);
    expHit("R6 R8 masked", 1, 32'h4007_0010);
    look(0, 32'h2008_0000);
    expMiss("R6 outside");
    chk("R10 one cycle", 32'(hitValid), 1);
    @(posedge clk); @(negedge clk);
    chk("R10 drop", 32'(hitValid), 0);
  endtask

  task automatic t_priority;
    wr(3, 0, mkUp(16'h2000, 11'h000, 1, 0));
    wr(3, 1, 32'h9000_0000);
    look(1, 32'h2001_0000);
    expHit("R9 lowest", 1, 32'h4001_0000);
    wr(1, 0, mkUp(16'h2000, 11'h003, 0, 0));
    look(1, 32'h2001_0000);
    expHit("R9 next", 3, 32'h9001_0000);
  endtask

  task automatic t_collide;
    wrEn = 1; wrLow = 0; wrIdx = 0; wrData = mkUp(16'h1000, 11'h000, 0, 0);
    lkValid = 1; lkSuper = 1; lkAddr = 32'h1001_2345;
    @(posedge clk); @(negedge clk);
    wrEn = 0; lkValid = 0;
    expHit("R11 old contents", 0, 32'h8001_2345);
    look(1, 32'h1001_2345);
    expMiss("R11 after write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1;
    @(negedge clk);
    t_reset;
    t_write_len;
    t_mask_err;
    t_priv_match;
    t_priority;
    t_collide;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule